// File: doc/BRIEF.md
# Omega Self-Routing Packet Network

This block joins N sources to N sinks through log2(N) columns of two-by-two switching elements. In front of every column the lanes are permuted by a perfect shuffle. Each packet carries the index of the sink it wants, and every column steers it using one bit of that index, so the network needs no routing tables. The default build has eight lanes (three columns) and byte-wide payloads.

The network is blocking. When two packets inside one element ask for the same output, one of them wins and the other is discarded for that cycle. The block raises a per-source flag that tells the losing source to present its packet again in a later cycle. The path through the columns is purely combinational. A single register bank at the end captures the delivered packets and the blocked flags, so results appear one clock after the inputs. The block holds no packets of its own.

Top module: `omega_net`

## Requirements
- R1: While `rst` is high, the next clock edge clears `out_valid` and `blocked` to all zeros, whatever the inputs are.
- R2: A packet presented in cycle t appears on the outputs after the clock edge that ends cycle t, and only for that one cycle.
- R3: A delivered packet appears on the output lane whose index equals its destination field, and carries its payload unchanged.
- R4: Before every column, the packet on lane p moves to lane ((p << 1) | (p >> (log2N − 1))) mod N. Column k (k = 0 first) reads destination bit log2N − 1 − k. Inside element e, lanes 2e and 2e+1 are its upper and lower inputs. A bit value of 0 sends the packet to lane 2e and a value of 1 sends it to lane 2e+1.
- R5: When both inputs of an element are valid and read the same bit value, the upper input goes through. The packet on the lower input is dropped, and the `blocked` bit of the source that issued it is set in the same output cycle.
- R6: Every valid input ends up in exactly one of two places, a set `out_valid` bit or its own set `blocked` bit, so the two counts together equal the number of valid inputs one cycle earlier.
- R7: A permutation in which source i targets sink i, or any cycle with a single valid packet, produces no blocked flag.
- R8: Inputs whose `in_valid` bit is low deliver nothing and never raise a `blocked` bit, whatever their destination and payload fields hold.
- R9: The blocked state does not persist. A dropped packet presented again alone in the next cycle is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N | Per-source packet present |
| in_dest | input | N*log2N | Per-source destination index, source i at bits [i*log2N +: log2N] |
| in_data | input | N*W | Per-source payload, source i at bits [i*W +: W] |
| out_valid | output | N | Per-sink packet delivered (registered) |
| out_data | output | N*W | Per-sink payload, sink j at bits [j*W +: W] (registered) |
| blocked | output | N | Per-source flag: packet dropped by contention (registered) |

## Verification
The bound checker tests four properties on every cycle. Valid inputs are conserved into deliveries plus blocked flags. A lone packet is never blocked. Idle or invalid inputs produce neither deliveries nor flags. Outputs are quiet on the first cycle after reset. Which lane a packet reaches, which contender wins inside an element, and whether a retry succeeds depend on the shuffle wiring and the bit chosen in each column. Only the bench scenarios show these. They compare the outputs against a lane-by-lane path computation and against hand-worked cases: a single conflict inside the first column, the identity permutation, single-packet sweeps, every source aimed at one sink, and pseudo-random traffic.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Setting an element takes in a given cycle
    typedef enum logic [1:0] {
        EL_IDLE     = 2'd0,
        EL_STRAIGHT = 2'd1,
        EL_CROSS    = 2'd2
    } el_mode_e;

    // One-bit left rotation of a lane index of the given width
    function automatic int unsigned shuffle_idx(input int unsigned idx, input int unsigned bits);
        int unsigned mask;
        mask = (1 << bits) - 1;
        return ((idx << 1) | (idx >> (bits - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int W      = 8,
    parameter int S      = 3,
    parameter int BITSEL = 2,
    localparam int PW    = W + 2 * S + 1
) (
    input  logic [PW-1:0] up_i,
    input  logic [PW-1:0] lo_i,
    output logic [PW-1:0] o0,
    output logic [PW-1:0] o1,
    output logic          lo_lost,
    output logic [S-1:0]  lo_src
);

    logic     up_v, lo_v, up_b, lo_b;
    el_mode_e mode;

    assign up_v    = up_i[PW-1];
    assign lo_v    = lo_i[PW-1];
    assign up_b    = up_i[W + BITSEL];
    assign lo_b    = lo_i[W + BITSEL];
    assign lo_lost = up_v && lo_v && (up_b == lo_b);
    assign lo_src  = lo_i[W + 2*S - 1 : W + S];

    // Setting: the upper input decides when present
    always_comb begin
        if (up_v)
            mode = up_b ? EL_CROSS : EL_STRAIGHT;
        else if (lo_v)
            mode = lo_b ? EL_STRAIGHT : EL_CROSS;
        else
            mode = EL_IDLE;
    end

    // Outputs for each setting; a losing lower packet is suppressed
    always_comb begin
        o0 = '0;
        o1 = '0;
        unique case (mode)
            EL_IDLE: begin
                o0 = '0;
                o1 = '0;
            end
            EL_STRAIGHT: begin
                o0 = up_i;
                o1 = lo_lost ? '0 : lo_i;
            end
            EL_CROSS: begin
                o0 = lo_lost ? '0 : lo_i;
                o1 = up_i;
            end
            default: begin
                o0 = '0;
                o1 = '0;
            end
        endcase
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int N    = 8,
    parameter int S    = 3,
    parameter int W    = 8,
    parameter int K    = 0,
    localparam int PW  = W + 2 * S + 1,
    localparam int NE  = N / 2,
    localparam int BIT = S - 1 - K
) (
    input  logic [N*PW-1:0] pkt_i,
    output logic [N*PW-1:0] pkt_o,
    output logic [N-1:0]    lost_o
);

    logic [N*PW-1:0] shuf;
    logic [NE-1:0]   el_lost;
    logic [S-1:0]    el_src [NE];

    // Perfect shuffle in front of the column
    for (genvar p = 0; p < N; p++) begin : g_shuf
        localparam int unsigned DST = shuffle_idx(p, S);
        assign shuf[DST*PW +: PW] = pkt_i[p*PW +: PW];
    end

    // Column of two-by-two elements
    for (genvar e = 0; e < NE; e++) begin : g_el
        omega_switch #(.W(W), .S(S), .BITSEL(BIT)) u_sw (
            .up_i    (shuf[(2*e)*PW +: PW]),
            .lo_i    (shuf[(2*e+1)*PW +: PW]),
            .o0      (pkt_o[(2*e)*PW +: PW]),
            .o1      (pkt_o[(2*e+1)*PW +: PW]),
            .lo_lost (el_lost[e]),
            .lo_src  (el_src[e])
        );
    end

    // Map each lost packet back to the source that issued it
    always_comb begin
        lost_o = '0;
        for (int e = 0; e < NE; e++) begin
            if (el_lost[e])
                lost_o[el_src[e]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
#(
    parameter int N   = 8,
    parameter int W   = 8,
    localparam int S  = $clog2(N),
    localparam int PW = W + 2 * S + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   in_valid,
    input  logic [N*S-1:0] in_dest,
    input  logic [N*W-1:0] in_data,
    output logic [N-1:0]   out_valid,
    output logic [N*W-1:0] out_data,
    output logic [N-1:0]   blocked
);

    logic [N*PW-1:0] bus     [S+1];
    logic [N-1:0]    lost_st [S];
    logic [N-1:0]    lost_any;
    logic [N-1:0]    arr_valid;
    logic [N*W-1:0]  arr_data;

    // Pack each source: {valid, source id, destination, payload}
    for (genvar i = 0; i < N; i++) begin : g_pack
        localparam logic [S-1:0] SRC_ID = S'(i);
        assign bus[0][i*PW +: PW] = {in_valid[i], SRC_ID, in_dest[i*S +: S], in_data[i*W +: W]};
    end

    // Chain of columns
    for (genvar k = 0; k < S; k++) begin : g_col
        omega_stage #(.N(N), .S(S), .W(W), .K(k)) u_col (
            .pkt_i  (bus[k]),
            .pkt_o  (bus[k+1]),
            .lost_o (lost_st[k])
        );
    end

    // Unpack the last column: lane index is the sink
    for (genvar j = 0; j < N; j++) begin : g_unpack
        assign arr_valid[j]         = bus[S][j*PW + PW - 1];
        assign arr_data[j*W +: W]   = bus[S][j*PW +: W];
    end

    always_comb begin
        lost_any = '0;
        for (int k = 0; k < S; k++)
            lost_any = lost_any | lost_st[k];
    end

    // Single output register bank
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= '0;
            out_data  <= '0;
            blocked   <= '0;
        end else begin
            out_valid <= arr_valid;
            out_data  <= arr_data;
            blocked   <= lost_any;
        end
    end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int S = $clog2(N)
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   in_valid,
    input logic [N*S-1:0] in_dest,
    input logic [N*W-1:0] in_data,
    input logic [N-1:0]   out_valid,
    input logic [N*W-1:0] out_data,
    input logic [N-1:0]   blocked
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0 && blocked == '0)); // R1

    AST_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(out_valid) + $countones(blocked) == $past($countones(in_valid)))); // R6

    AST_LONE_NO_BLOCK: assert property (@(posedge clk) disable iff (rst)
        ($countones(in_valid) == 1) |=> (blocked == '0 && $countones(out_valid) == 1)); // R7

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid == '0) |=> (out_valid == '0 && blocked == '0)); // R8

    AST_BLOCK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((blocked & ~$past(in_valid)) == '0)); // R8

endmodule

bind omega_net omega_net_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/sim_omega_net.sv
module sim_omega_net;

    localparam int N = 8;
    localparam int W = 8;
    localparam int S = $clog2(N);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   in_valid = '0;
    logic [N*S-1:0] in_dest = '0;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   out_valid;
    logic [N*W-1:0] out_data;
    logic [N-1:0]   blocked;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] lf = 32'h1ACE_B00C;

    typedef struct {
        logic [N-1:0]   v;
        logic [N*W-1:0] d;
        logic [N-1:0]   b;
        string          tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    omega_net #(.N(N), .W(W)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference path computation built from the routing rules (R4, R5)
    task automatic model(input logic [N-1:0] v, input logic [N*S-1:0] d, input logic [N*W-1:0] dt,
                         output logic [N-1:0] ev, output logic [N*W-1:0] ed, output logic [N-1:0] eb);
        int occ[N];
        int nxt[N];
        ev = '0; ed = '0; eb = '0;
        for (int p = 0; p < N; p++) occ[p] = v[p] ? p : -1;
        for (int k = 0; k < S; k++) begin
            for (int p = 0; p < N; p++) nxt[((p << 1) | (p >> (S - 1))) & (N - 1)] = occ[p];
            for (int p = 0; p < N; p++) occ[p] = -1;
            for (int e = 0; e < N / 2; e++) begin
                int u, l, bu, bl;
                u = nxt[2*e];
                l = nxt[2*e+1];
                bu = (u >= 0) ? int'(d[u*S + S - 1 - k]) : 0;
                bl = (l >= 0) ? int'(d[l*S + S - 1 - k]) : 0;
                if (u >= 0) occ[2*e + bu] = u;
                if (l >= 0) begin
                    if (u >= 0 && bu == bl) eb[l] = 1'b1;
                    else occ[2*e + bl] = l;
                end
            end
        end
        for (int p = 0; p < N; p++)
            if (occ[p] >= 0) begin
                ev[p] = 1'b1;
                ed[p*W +: W] = dt[occ[p]*W +: W];
            end
    endtask

    // Driver: present one cycle of inputs and queue what must come out
    task automatic send_exp(input logic [N-1:0] v, input logic [N*S-1:0] d, input logic [N*W-1:0] dt,
                            input logic [N-1:0] ev, input logic [N*W-1:0] ed, input logic [N-1:0] eb,
                            input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = v;
        in_dest  = d;
        in_data  = dt;
        it.v = ev; it.d = ed; it.b = eb; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic send_model(input logic [N-1:0] v, input logic [N*S-1:0] d, input logic [N*W-1:0] dt,
                              input string tag);
        logic [N-1:0]   ev, eb;
        logic [N*W-1:0] ed;
        model(v, d, dt, ev, ed, eb);
        send_exp(v, d, dt, ev, ed, eb, tag);
    endtask

    // Monitor: compare each registered result against the queue
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t it;
                logic [N*W-1:0] am, em;
                it = q.pop_front();
                am = '0; em = '0;
                for (int j = 0; j < N; j++)
                    if (it.v[j]) begin
                        am[j*W +: W] = out_data[j*W +: W];
                        em[j*W +: W] = it.d[j*W +: W];
                    end
                chk(out_valid == it.v, {it.tag, " out_valid"}, N*W'(out_valid), N*W'(it.v));
                chk(am == em,          {it.tag, " out_data"},  am, em);
                chk(blocked == it.b,   {it.tag, " blocked"},   N*W'(blocked), N*W'(it.b));
            end
        end
    end

    // Watchdog
    initial begin
        #(10 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0]   v, ev, eb;
        logic [N*S-1:0] d;
        logic [N*W-1:0] dt, ed;

        // R1: reset dominates active inputs
        in_valid = '1;
        for (int i = 0; i < N; i++) in_dest[i*S +: S] = S'(N - 1 - i);
        repeat (3) @(posedge clk);
        #2;
        chk(out_valid == '0, "R1 out_valid in reset", N*W'(out_valid), '0);
        chk(blocked == '0,   "R1 blocked in reset",   N*W'(blocked), '0);
        @(negedge clk);
        in_valid = '0;
        rst = 1'b0;

        for (int i = 0; i < N; i++) dt[i*W +: W] = W'(8'h10 + i);

        // R7: identity permutation, hand-derived expectation
        for (int i = 0; i < N; i++) d[i*S +: S] = S'(i);
        send_exp('1, d, dt, '1, dt, '0, "R7 identity");

        // R5/R4: sources 0 and 4 meet in element 0 of column 0, upper wins
        d = '0; v = '0;
        v[0] = 1'b1; d[0*S +: S] = S'(1);
        v[4] = 1'b1; d[4*S +: S] = S'(2);
        ev = '0; ed = '0; eb = '0;
        ev[1] = 1'b1; ed[1*W +: W] = dt[0*W +: W];
        eb[4] = 1'b1;
        send_exp(v, d, dt, ev, ed, eb, "R5 R4 upper wins");

        // R9: retry of the dropped packet alone
        v = '0; v[4] = 1'b1;
        ev = '0; ed = '0;
        ev[2] = 1'b1; ed[2*W +: W] = dt[4*W +: W];
        send_exp(v, d, dt, ev, ed, '0, "R9 retry delivered");

        // R2/R3: one packet per cycle, sink index from destination
        for (int s = 0; s < N; s++) begin
            int t;
            t = (s * 3 + 1) % N;
            v = '0; v[s] = 1'b1;
            d = '0; d[s*S +: S] = S'(t);
            ev = '0; ed = '0;
            ev[t] = 1'b1; ed[t*W +: W] = dt[s*W +: W];
            send_exp(v, d, dt, ev, ed, '0, "R2 R3 single packet");
        end

        // R8: invalid inputs with non-zero fields
        for (int i = 0; i < N; i++) d[i*S +: S] = S'(i ^ 5);
        send_exp('0, d, dt, '0, '0, '0, "R8 all invalid");
        v = '0; v[2] = 1'b1; v[5] = 1'b1;
        send_model(v, d, dt, "R8 partial valid");

        // R5/R6: every source aimed at sink 0
        send_model('1, '0, dt, "R5 R6 all to sink 0");

        // R6: bit reversal and rotations
        for (int i = 0; i < N; i++) d[i*S +: S] = {<<{S'(i)}};
        send_model('1, d, dt, "R6 bit reversal");
        for (int r = 1; r < N; r++) begin
            for (int i = 0; i < N; i++) d[i*S +: S] = S'((i + r) % N);
            send_model('1, d, dt, "R3 R6 rotation");
        end

        // R3/R5/R6: pseudo-random traffic
        for (int n = 0; n < 60; n++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            v = lf[N-1:0];
            d = lf[31 -: N*S];
            for (int i = 0; i < N; i++) dt[i*W +: W] = W'(lf[7:0] + 8'(i * 37));
            send_model(v, d, dt, "R3 R5 R6 random");
        end

        send_exp('0, '0, '0, '0, '0, '0, "R8 idle");
        wait (q.size() == 0);
        @(posedge clk);
        #4;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule